// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Core

This core is a countdown watchdog with two chained expiry stages. Once armed, it counts down a first interval. When that interval runs out, it issues a warning: an ordinary interrupt request, a system-management request, or nothing, depending on a configuration field. It then counts down a second interval at once. If the second interval also runs out, the core asks for a system reset and records that fact in a sticky flag. Software keeps the system alive by sending a one-cycle ping, which always sends the counter back to the start of the first stage.

Each stage has its own 20-bit preload. The core runs from a fixed 33 MHz time base. A scale select sets the unit of each preload: in the slow scale one unit is 2^15 clock cycles, and in the fast scale it is 2^5 clock cycles. In free-run mode the core starts the first stage again after the second stage expires; otherwise it stops. The register access path, any write protection and the reset generator itself belong to the surrounding logic, which drives these plain control pins and uses the request outputs.

Top module: `wdt2_core`

## Requirements
- R1: After reset, `irq_req`, `smi_req`, `reboot_req` and `prev_reboot` are 0 and `stage` reads 1 (encoding: 1 = first stage, 2 = second stage). The core is idle until `enable` rises.
- R2: A stage lasts L clock cycles. L is the preload shifted left by 5 when `fast_scale` is 1, and shifted left by 15 when it is 0. If `enable` rises before clock edge E0, the first expiry occurs on edge E0+L1.
- R3: Arming happens only on a 0-to-1 change of `enable`, and it loads the first stage from `preload_one`. While `enable` is 0 the count is frozen and no request pulses appear. The `stage` value is held.
- R4: A `ping` while `enable` is 1 restarts the first stage from `preload_one`, whatever the current stage. A `ping` while `enable` is 0 changes nothing.
- R5: At first-stage expiry, `warn_kind` selects the warning. A value of 0 gives a one-cycle `irq_req` pulse, 2 gives a one-cycle `smi_req` pulse, and 1 or 3 give no pulse.
- R6: `stage` reads 2 from the cycle after first-stage expiry, which is the same cycle as the warning pulse. The second stage then lasts L2 cycles, computed from `preload_two`.
- R7: At second-stage expiry with `reboot_off` = 0, `reboot_req` pulses for one cycle and `prev_reboot` is 1 from that same cycle. With `reboot_off` = 1, neither happens.
- R8: After second-stage expiry, `free_run` = 1 restarts the first stage, so `stage` reads 1 in the cycle after expiry. `free_run` = 0 stops counting: `stage` stays 2 and no further pulses come until the core is re-armed or pinged.
- R9: `prev_reboot` stays set until a cycle with `flag_clr` = 1. Neither `ping` nor deasserting `enable` clears it. A reboot and `flag_clr` on the same edge leave the flag set.
- R10: A preload of 0 gives a stage of one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz time base |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Arms on a rising edge; counting stops while low |
| ping | input | 1 | One-cycle keep-alive pulse |
| preload_one | input | 20 | First-stage interval in scale units |
| preload_two | input | 20 | Second-stage interval in scale units |
| fast_scale | input | 1 | 1: unit is 2^5 cycles; 0: unit is 2^15 cycles |
| warn_kind | input | 2 | First-stage warning: 0 IRQ, 2 SMI, 1 or 3 none |
| reboot_off | input | 1 | 1 suppresses the reset request |
| free_run | input | 1 | 1 restarts the first stage after final expiry |
| flag_clr | input | 1 | Clears the sticky previous-reboot flag |
| irq_req | output | 1 | One-cycle interrupt request |
| smi_req | output | 1 | One-cycle system-management request |
| reboot_req | output | 1 | One-cycle reset request |
| prev_reboot | output | 1 | Sticky flag: the watchdog caused a reset |
| stage | output | 2 | Current stage, 1 or 2 |

## Verification
The vector table arms the core with several combinations of preloads, scale, warning kind and reboot suppression, all in free-run mode. For each combination it measures both stage lengths to the exact cycle and counts every request pulse. Unequal preloads separate the first interval from the second. The single slow-scale vector separates the two shift amounts. The zero preload exposes the one-cycle floor. The warning kinds 0, 1, 2 and 3 separate the IRQ and SMI decodes from the silent codes. Directed runs then cover a late ping that lands in the second stage, a ping while disabled, a stop in the middle of a count, the stop that follows final expiry without free-run, and the set-versus-clear race on the sticky flag.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

  typedef enum logic [1:0] {
    STG_ONE = 2'd1,
    STG_TWO = 2'd2
  } stage_e;

  localparam logic [1:0] WARN_IRQ = 2'd0;
  localparam logic [1:0] WARN_SMI = 2'd2;

endpackage

// File: rtl/wdt2_len.sv
module wdt2_len #(
  parameter int PRE_W    = 20,
  parameter int SLOW_SH  = 15,
  parameter int FAST_SH  = 5,
  parameter int CNT_W    = 35
) (
  input  logic [PRE_W-1:0] preload,
  input  logic             fast,
  output logic [CNT_W-1:0] len
);

  logic [CNT_W-1:0] wide;
  logic [CNT_W-1:0] scaled;

  assign wide   = {{(CNT_W-PRE_W){1'b0}}, preload};
  assign scaled = fast ? (wide << FAST_SH) : (wide << SLOW_SH);
  // zero preload still yields a one-cycle stage (R10)
  assign len    = (preload == '0) ? CNT_W'(1) : scaled;

  always_comb begin
    assert_len_floor_R10: assert (len != '0);
  end

endmodule

// File: rtl/wdt2_ctrl.sv
module wdt2_ctrl
  import wdt2_pkg::*;
#(
  parameter int CNT_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ping,
  input  logic             free_run,
  input  logic [CNT_W-1:0] len_one,
  input  logic [CNT_W-1:0] len_two,
  output logic             fire_one,
  output logic             fire_two,
  output logic [1:0]       stage_o
);

  logic             en_q;
  logic             running_q;
  stage_e           stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             arm;
  logic             advance;
  logic             at_end;

  assign arm      = enable && (!en_q || ping);
  assign advance  = enable && en_q && !ping && running_q;
  assign at_end   = (cnt_q <= CNT_W'(1));
  assign fire_one = advance && at_end && (stage_q == STG_ONE);
  assign fire_two = advance && at_end && (stage_q == STG_TWO);
  assign stage_o  = stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      running_q <= 1'b0;
      stage_q   <= STG_ONE;
      cnt_q     <= '0;
    end else begin
      en_q <= enable;
      if (!enable) begin
        running_q <= 1'b0;
      end else if (arm) begin
        running_q <= 1'b1;
        stage_q   <= STG_ONE;
        cnt_q     <= len_one;
      end else if (fire_one) begin
        stage_q <= STG_TWO;
        cnt_q   <= len_two;
      end else if (fire_two) begin
        if (free_run) begin
          stage_q <= STG_ONE;
          cnt_q   <= len_one;
        end else begin
          running_q <= 1'b0;
        end
      end else if (advance) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assert_disable_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !running_q);
  assert_ping_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_q && ping) |=> (stage_q == STG_ONE && cnt_q == $past(len_one)));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !at_end) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_enter_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_one |=> (stage_q == STG_TWO && cnt_q == $past(len_two)));
  assert_stop_no_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_two && !free_run) |=> (!running_q && stage_q == STG_TWO));
  assert_free_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_two && free_run) |=> (stage_q == STG_ONE));

endmodule

// File: rtl/wdt2_event.sv
module wdt2_event
  import wdt2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_one,
  input  logic       fire_two,
  input  logic [1:0] warn_kind,
  input  logic       reboot_off,
  input  logic       flag_clr,
  output logic       irq_req,
  output logic       smi_req,
  output logic       reboot_req,
  output logic       prev_reboot
);

  logic boot_now;

  assign boot_now = fire_two && !reboot_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req     <= 1'b0;
      smi_req     <= 1'b0;
      reboot_req  <= 1'b0;
      prev_reboot <= 1'b0;
    end else begin
      irq_req    <= fire_one && (warn_kind == WARN_IRQ);
      smi_req    <= fire_one && (warn_kind == WARN_SMI);
      reboot_req <= boot_now;
      // a new reboot wins over a clear on the same edge (R9)
      if (boot_now)
        prev_reboot <= 1'b1;
      else if (flag_clr)
        prev_reboot <= 1'b0;
    end
  end

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  assert_smi_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |=> !smi_req);
  assert_one_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_req, smi_req, reboot_req}));
  assert_flag_on_boot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> prev_reboot);
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_reboot && !flag_clr) |=> prev_reboot);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prev_reboot) |-> $past(flag_clr));

endmodule

// File: rtl/wdt2_core.sv
module wdt2_core #(
  parameter int PRE_W   = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ping,
  input  logic [PRE_W-1:0] preload_one,
  input  logic [PRE_W-1:0] preload_two,
  input  logic             fast_scale,
  input  logic [1:0]       warn_kind,
  input  logic             reboot_off,
  input  logic             free_run,
  input  logic             flag_clr,
  output logic             irq_req,
  output logic             smi_req,
  output logic             reboot_req,
  output logic             prev_reboot,
  output logic [1:0]       stage
);

  localparam int SH_MAX = (SLOW_SH > FAST_SH) ? SLOW_SH : FAST_SH;
  localparam int CNT_W  = PRE_W + SH_MAX;
  localparam int N_STG  = 2;

  logic [PRE_W-1:0] pre_arr [N_STG];
  logic [CNT_W-1:0] len_arr [N_STG];
  logic             fire_one;
  logic             fire_two;

  assign pre_arr[0] = preload_one;
  assign pre_arr[1] = preload_two;

  for (genvar g = 0; g < N_STG; g++) begin : g_len
    wdt2_len #(
      .PRE_W  (PRE_W),
      .SLOW_SH(SLOW_SH),
      .FAST_SH(FAST_SH),
      .CNT_W  (CNT_W)
    ) u_len (
      .preload(pre_arr[g]),
      .fast   (fast_scale),
      .len    (len_arr[g])
    );
  end

  wdt2_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .ping    (ping),
    .free_run(free_run),
    .len_one (len_arr[0]),
    .len_two (len_arr[1]),
    .fire_one(fire_one),
    .fire_two(fire_two),
    .stage_o (stage)
  );

  wdt2_event u_event (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_one   (fire_one),
    .fire_two   (fire_two),
    .warn_kind  (warn_kind),
    .reboot_off (reboot_off),
    .flag_clr   (flag_clr),
    .irq_req    (irq_req),
    .smi_req    (smi_req),
    .reboot_req (reboot_req),
    .prev_reboot(prev_reboot)
  );

  assert_stage_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd1) || (stage == 2'd2));

endmodule

// File: tb/tb_wdt2_core.sv
module tb_wdt2_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, ping = 1'b0, fast_scale = 1'b0;
  logic [19:0] preload_one = '0, preload_two = '0;
  logic [1:0]  warn_kind = 2'd0;
  logic        reboot_off = 1'b0, free_run = 1'b0, flag_clr = 1'b0;
  logic        irq_req, smi_req, reboot_req, prev_reboot;
  logic [1:0]  stage;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wdt2_core dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ping(ping),
    .preload_one(preload_one), .preload_two(preload_two),
    .fast_scale(fast_scale), .warn_kind(warn_kind), .reboot_off(reboot_off),
    .free_run(free_run), .flag_clr(flag_clr), .irq_req(irq_req),
    .smi_req(smi_req), .reboot_req(reboot_req), .prev_reboot(prev_reboot),
    .stage(stage)
  );

  typedef struct packed {
    logic        fast;
    logic [19:0] p1;
    logic [19:0] p2;
    logic [1:0]  kind;
    logic        off;
    logic        e_irq;
    logic        e_smi;
    logic        e_rb;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 20'd3, 20'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 20'd1, 20'd4, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b1, 20'd2, 20'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 20'd5, 20'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b0, 20'd1, 20'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 20'd0, 20'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  function automatic int stage_len(input int p, input logic fast);
    if (p == 0) return 1;
    return fast ? (p << 5) : (p << 15);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int c_irq, c_smi, c_rb;
  task automatic tally();
    c_irq += int'(irq_req);
    c_smi += int'(smi_req);
    c_rb  += int'(reboot_req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int k, j;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "irq_req", int'(irq_req), 0);
    chk("R1", "smi_req", int'(smi_req), 0);
    chk("R1", "reboot_req", int'(reboot_req), 0);
    chk("R1", "prev_reboot", int'(prev_reboot), 0);
    chk("R1", "stage", int'(stage), 1);

    // vector table, free-run, R2 R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      enable = 1'b0; flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      fast_scale = VECS[v].fast; preload_one = VECS[v].p1; preload_two = VECS[v].p2;
      warn_kind = VECS[v].kind; reboot_off = VECS[v].off; free_run = 1'b1;
      @(negedge clk);
      enable = 1'b1;
      c_irq = 0; c_smi = 0; c_rb = 0;
      k = 0;
      do begin @(negedge clk); k++; tally(); end while (stage != 2'd2 && k < 70000);
      chk("R2", $sformatf("v%0d stage-one length", v), k - 1,
          stage_len(int'(VECS[v].p1), VECS[v].fast));
      chk("R5", $sformatf("v%0d irq at switch", v), int'(irq_req), int'(VECS[v].e_irq));
      chk("R5", $sformatf("v%0d smi at switch", v), int'(smi_req), int'(VECS[v].e_smi));
      j = 0;
      do begin @(negedge clk); j++; tally(); end while (stage != 2'd1 && j < 70000);
      enable = 1'b0;
      chk("R6", $sformatf("v%0d stage-two length", v), j,
          stage_len(int'(VECS[v].p2), VECS[v].fast));
      chk("R7", $sformatf("v%0d reboot at end", v), int'(reboot_req), int'(VECS[v].e_rb));
      chk("R7", $sformatf("v%0d prev flag", v), int'(prev_reboot), int'(VECS[v].e_rb));
      chk("R5", $sformatf("v%0d irq pulses", v), c_irq, int'(VECS[v].e_irq));
      chk("R5", $sformatf("v%0d smi pulses", v), c_smi, int'(VECS[v].e_smi));
      chk("R7", $sformatf("v%0d reboot pulses", v), c_rb, int'(VECS[v].e_rb));
      chk("R8", $sformatf("v%0d free-run back to one", v), int'(stage), 1);
    end

    // R3: disable stops counting mid-stage
    @(negedge clk);
    fast_scale = 1'b1; preload_one = 20'd2; preload_two = 20'd4;
    warn_kind = 2'd0; reboot_off = 1'b0; free_run = 1'b0;
    enable = 1'b1;
    repeat (10) @(negedge clk);
    enable = 1'b0;
    c_irq = 0; c_smi = 0; c_rb = 0;
    repeat (200) begin @(negedge clk); tally(); end
    chk("R3", "pulses while disabled", c_irq + c_smi + c_rb, 0);
    chk("R3", "stage held", int'(stage), 1);

    // R4: ping in stage two restarts stage one from preload_one
    enable = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (stage != 2'd2 && k < 1000);
    chk("R3", "rise re-arms stage-one length", k - 1, 64);
    repeat (5) @(negedge clk);
    ping = 1'b1;
    @(negedge clk);
    ping = 1'b0;
    chk("R4", "ping returns to stage one", int'(stage), 1);
    k = 1;
    do begin @(negedge clk); k++; end while (stage != 2'd2 && k < 1000);
    chk("R4", "stage-one length after ping", k - 1, 64);
    // R4: ping while disabled is ignored
    enable = 1'b0;
    @(negedge clk);
    ping = 1'b1;
    @(negedge clk);
    ping = 1'b0;
    c_irq = 0; c_smi = 0; c_rb = 0;
    repeat (3) begin @(negedge clk); tally(); end
    chk("R4", "ping while disabled keeps stage", int'(stage), 2);
    chk("R4", "ping while disabled no pulse", c_irq + c_smi + c_rb, 0);

    // R8 stop without free-run, R9 set wins over clear, R10 zero preload
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    preload_one = 20'd0; preload_two = 20'd0; free_run = 1'b0; reboot_off = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10", "one-cycle first stage", int'(stage), 2);
    chk("R5", "irq on zero preload", int'(irq_req), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R7", "reboot pulse", int'(reboot_req), 1);
    chk("R9", "set wins over clear", int'(prev_reboot), 1);
    c_irq = 0; c_smi = 0; c_rb = 0;
    repeat (300) begin @(negedge clk); tally(); end
    chk("R8", "stopped without free-run", c_irq + c_smi + c_rb, 0);
    chk("R8", "stage stays two", int'(stage), 2);
    // R9: ping and disable leave the flag alone
    reboot_off = 1'b1;
    ping = 1'b1;
    @(negedge clk);
    ping = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9", "flag after ping", int'(prev_reboot), 1);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "flag after disable", int'(prev_reboot), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9", "flag cleared by flag_clr", int'(prev_reboot), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule